// File: doc/BRIEF.md
# GPIO Port with Masked Bit Access

This block is a general-purpose I/O port of N pins that sits on a simple single-cycle register bus. Software can change the output latch in four ways. It can write the whole data register, filtered by a write-protect mask. It can write to a set register or a clear register, which touches only the pins named in the write data and needs no prior read. It can also store to a per-pin alias address, which changes one pin with a single plain word store.

A direction register chooses, for each pin, whether the latch drives the pad or the pin is an input. Input pads pass through a two-flop synchronizer. Reads of the data register then return the synchronized pad level for input pins and the latch value for output pins.

The bus is addressed by word: word address = byte offset / 4. The bus data width equals N. Read data is combinational while a read is presented.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, padOut, padOe, the direction register and the mask register are all zero.
- R2: A write to the data register (word 0) loads the write data into every unmasked latch bit. padOut shows the new value from the cycle after the write.
- R3: During a data-register write, every latch bit whose mask bit (word 3, readable) is 1 keeps its previous value.
- R4: A write to the set register (word 1) drives to 1 every latch bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A write to the clear register (word 2) drives to 0 every latch bit whose write-data bit is 1 and leaves the others unchanged. The set and clear registers read as zero.
- R6: The mask has no effect on set, clear or alias writes.
- R7: A write to alias word 0x40+i (byte 0x100+4i), for i < N, sets latch bit i to write-data bit 0. The upper data bits are ignored and no other pin changes.
- R8: A read of alias word 0x40+i returns pin level i in bit 0, with zeros in all higher bits.
- R9: padOe equals the direction register (word 4, readable; 1 = output). padOut equals the latch. A data-register read returns the latch for output pins and the synchronized pad for input pins.
- R10: A pad change on an input pin becomes visible to reads after exactly two rising clock edges. It is not visible after one.
- R11: Reads of unmapped words, including alias words with i >= N, return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Access valid this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | AW | Word address |
| busWdata | input | N | Write data |
| busRdata | output | N | Read data (combinational) |
| padIn | input | N | Asynchronous pad levels |
| padOut | output | N | Output latch |
| padOe | output | N | Output enable per pin |

## Verification
Two things can meet in one cycle: a full data-register write to pins configured as inputs, and a change in level on those same pads. The bench changes the pads in the same cycle as a masked data write. It then checks that padOut holds the masked write result while data reads return the synchronized pads two edges later. After the direction is switched to output, the same read must return the written latch bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    RD_NONE,
    RD_DATA,
    RD_MASK,
    RD_DIR,
    RD_ALIAS
  } rdSel_e;

  typedef struct packed {
    logic       wrData;
    logic       wrSet;
    logic       wrClr;
    logic       wrMask;
    logic       wrDir;
    logic       wrAlias;
    logic [4:0] aliasIdx;
    rdSel_e     rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busEn,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  output strobe_t       strobe
);
  localparam logic [5:0] NUM_PINS = 6'(N);

  logic regionRegs;
  logic regionAlias;
  logic aliasHit;
  logic [4:0] idx;

  always_comb begin
    idx         = busAddr[4:0];
    regionRegs  = (busAddr[AW-1:3] == '0);
    regionAlias = (busAddr[AW-1:6] == (AW-6)'(1)) && !busAddr[5];
    aliasHit    = regionAlias && ({1'b0, idx} < NUM_PINS);

    strobe          = '0;
    strobe.aliasIdx = idx;
    if (busEn && busWe) begin
      strobe.wrData  = regionRegs && (busAddr[2:0] == 3'd0);
      strobe.wrSet   = regionRegs && (busAddr[2:0] == 3'd1);
      strobe.wrClr   = regionRegs && (busAddr[2:0] == 3'd2);
      strobe.wrMask  = regionRegs && (busAddr[2:0] == 3'd3);
      strobe.wrDir   = regionRegs && (busAddr[2:0] == 3'd4);
      strobe.wrAlias = aliasHit;
    end
    if (busEn && !busWe) begin
      if (aliasHit) strobe.rdSel = RD_ALIAS;
      else if (regionRegs) begin
        case (busAddr[2:0])
          3'd0:    strobe.rdSel = RD_DATA;
          3'd3:    strobe.rdSel = RD_MASK;
          3'd4:    strobe.rdSel = RD_DIR;
          default: strobe.rdSel = RD_NONE;
        endcase
      end
    end
  end

  // R11: one access selects at most one write path; unmapped selects none
  p_single_path_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrData, strobe.wrSet, strobe.wrClr,
              strobe.wrMask, strobe.wrDir, strobe.wrAlias}));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobe,
  input  logic [N-1:0] busWdata,
  input  logic [N-1:0] padIn,
  output logic [N-1:0] busRdata,
  output logic [N-1:0] padOut,
  output logic [N-1:0] padOe
);
  logic [N-1:0] outLat, dirReg, maskReg;
  logic [N-1:0] syncA, syncB;
  logic [N-1:0] pinLevel;
  logic [N-1:0] setBits, clrBits, aliasSel;
  logic [N-1:0] nextLat;
  logic         aliasLevel;

  for (genvar i = 0; i < N; i++) begin : g_alias
    assign aliasSel[i] = (strobe.aliasIdx == 5'(i));
  end

  always_comb begin
    setBits = strobe.wrSet ? busWdata : '0;
    clrBits = strobe.wrClr ? busWdata : '0;
    nextLat = outLat;
    if (strobe.wrData)
      nextLat = (outLat & maskReg) | (busWdata & ~maskReg);
    // clear wins over set on the same bit
    nextLat = (nextLat | setBits) & ~clrBits;
    if (strobe.wrAlias)
      nextLat = (nextLat & ~aliasSel) | (aliasSel & {N{busWdata[0]}});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLat  <= '0;
      dirReg  <= '0;
      maskReg <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      outLat <= nextLat;
      if (strobe.wrMask) maskReg <= busWdata;
      if (strobe.wrDir)  dirReg  <= busWdata;
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    pinLevel   = (dirReg & outLat) | (~dirReg & syncB);
    aliasLevel = |(pinLevel & aliasSel);
    busRdata   = '0;
    case (strobe.rdSel)
      RD_DATA:  busRdata = pinLevel;
      RD_MASK:  busRdata = maskReg;
      RD_DIR:   busRdata = dirReg;
      RD_ALIAS: busRdata[0] = aliasLevel;
      default:  busRdata = '0;
    endcase
  end

  assign padOut = outLat;
  assign padOe  = dirReg;

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrData |=> ((outLat & $past(maskReg)) == ($past(outLat) & $past(maskReg))));
  p_set_bits_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSet |=> (outLat == ($past(outLat) | $past(busWdata))));
  p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrClr |=> (outLat == ($past(outLat) & ~$past(busWdata))));
  p_alias_one_pin_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrAlias |=> ($countones(outLat ^ $past(outLat)) <= 1));
  p_alias_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_ALIAS) |-> ((busRdata >> 1) == '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busEn,
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  input  logic [N-1:0]  busWdata,
  output logic [N-1:0]  busRdata,
  input  logic [N-1:0]  padIn,
  output logic [N-1:0]  padOut,
  output logic [N-1:0]  padOe
);
  strobe_t strobe;

  gpio_ctrl #(.N(N), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe),
    .busAddr(busAddr), .strobe(strobe)
  );

  gpio_datapath #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .padIn(padIn), .busRdata(busRdata), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
  localparam int N  = 16;
  localparam int AW = 10;

  logic          clk = 0;
  logic          rstN = 0;
  logic          busEn = 0;
  logic          busWe = 0;
  logic [AW-1:0] busAddr = '0;
  logic [N-1:0]  busWdata = '0;
  logic [N-1:0]  busRdata;
  logic [N-1:0]  padIn = '0;
  logic [N-1:0]  padOut, padOe;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] rd;

  always #2 clk = ~clk;

  gpio_mask_port #(.N(N), .AW(AW)) uut (.*);

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk);
    busEn = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 0; busWe = 0;
  endtask

  task automatic busRead(logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    busEn = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    busEn = 0;
  endtask

  task automatic t_reset;
    check("R1 padOut", padOut, '0);
    check("R1 padOe", padOe, '0);
    busRead(10'd3, rd); check("R1 mask", rd, '0);
    busRead(10'd4, rd); check("R1 dir", rd, '0);
  endtask

  task automatic t_data;
    busWrite(10'd4, 16'hFFFF);
    busWrite(10'd0, 16'hA5C3);
    check("R2 padOut", padOut, 16'hA5C3);
    busRead(10'd0, rd); check("R2 read", rd, 16'hA5C3);
    check("R9 padOe", padOe, 16'hFFFF);
  endtask

  task automatic t_mask;
    busWrite(10'd3, 16'h00FF);
    busRead(10'd3, rd); check("R3 mask read", rd, 16'h00FF);
    busWrite(10'd0, 16'h1234);
    check("R3 masked write", padOut, 16'h12C3);
  endtask

  task automatic t_setclr;
    busWrite(10'd1, 16'h000C);
    check("R4 set", padOut, 16'h12CF);
    busWrite(10'd2, 16'h1201);
    check("R5 clear", padOut, 16'h00CE);
    busRead(10'd1, rd); check("R5 set reads zero", rd, '0);
    busRead(10'd2, rd); check("R5 clear reads zero", rd, '0);
  endtask

  task automatic t_alias;
    busWrite(10'h4F, 16'hFFFF);
    check("R7 alias pin15", padOut, 16'h80CE);
    busWrite(10'h41, 16'hFFFE);
    check("R6 alias on masked pin1", padOut, 16'h80CC);
    busRead(10'h4F, rd); check("R8 alias read pin15", rd, 16'h0001);
    busRead(10'h40, rd); check("R8 alias read pin0", rd, 16'h0000);
  endtask

  task automatic t_input;
    busWrite(10'd4, 16'h00FF);
    check("R9 padOe", padOe, 16'h00FF);
    @(negedge clk); padIn = 16'h5A00;
    busRead(10'd0, rd); check("R10 one edge", rd, 16'h00CC);
    busRead(10'd0, rd); check("R10 two edges", rd, 16'h5ACC);
    check("R9 padOut latch", padOut, 16'h80CC);
  endtask

  task automatic t_collide;
    @(negedge clk);
    padIn = 16'hFF00;
    busEn = 1; busWe = 1; busAddr = 10'd0; busWdata = 16'h3333;
    @(negedge clk);
    busEn = 0; busWe = 0;
    check("R3 write with pad change", padOut, 16'h33CC);
    busRead(10'd0, rd); check("R9 input pins show pad", rd, 16'hFFCC);
    busWrite(10'd4, 16'hFFFF);
    busRead(10'd0, rd); check("R9 output pins show latch", rd, 16'h33CC);
  endtask

  task automatic t_unmapped;
    busWrite(10'h08, 16'hFFFF);
    busWrite(10'h50, 16'hFFFF);
    check("R11 write ignored", padOut, 16'h33CC);
    busRead(10'd3, rd); check("R11 mask untouched", rd, 16'h00FF);
    busRead(10'd4, rd); check("R11 dir untouched", rd, 16'hFFFF);
    busRead(10'h08, rd); check("R11 read zero", rd, '0);
    busRead(10'h50, rd); check("R11 alias beyond N", rd, '0);
    busRead(10'd5, rd); check("R11 word5 zero", rd, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset;
    t_data;
    t_mask;
    t_setclr;
    t_alias;
    t_input;
    t_collide;
    t_unmapped;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule